// File: doc/BRIEF.md
# Challenge-Response Nibble Mixer

This block answers the challenge phase of a lockout handshake that follows boot. After reset it holds a 16-entry state of 8-bit words, seeded from one of two nibble tables chosen by a region input. The host then clocks in two nibbles, most significant bit first. The second nibble replaces state entry 1. The first nibble belongs to the lower half of the 32-entry table, which this block never reads, so it is taken in and then dropped.

Each command is a one-cycle `start` pulse. It runs a fixed number of mixing rounds over the state. The default is three. A round is a data-dependent chain of additions, exchanges with the accumulator, one inversion and additions that only happen when a sum stays below 16.

The block then serves one response bit for each host bit that arrives. The response bit is bit 0 of an entry. The first entry is picked by the low nibble of entry 7, and the walk goes up or down depending on the region. `done` is raised together with the last bit. The state is kept for the next command until reset.

Top module: `cmp_mix_engine`

## Requirements
- R1: While `rst_n` is low, `tx_ready` and `done` read 0 one edge later. Each state entry k (0..15) is loaded with nibble 16+k of the table picked by `region` (0 selects table A, 1 selects table B), zero-extended to 8 bits. Nibble n of a table is bits [4n+3:4n].
- R2: After reset, the first eight accepted `rx_valid` bits form two nibbles, most significant bit first. The second nibble, zero-extended, replaces state entry 1. The first nibble is discarded.
- R3: `start` has no effect until all eight initial bits are taken, and none while a command is running. An accepted `start` begins a command.
- R4: A command runs ROUNDS mixing rounds (default 3). All arithmetic uses 8-bit words with wraparound. A round sets x = entry 15 and a = x. It then repeats passes until x, updated as (x+15) mod 16 after each pass, equals 15.
- R5: One pass takes these steps in order, with pointer p:
  - e1 = a+e1+1 and a takes it.
  - t = a+e2+1; a takes the old e2, and e2 becomes the inverse of t.
  - t = (a mod 16)+(e3 mod 16)+1. If t<16, a takes the old e3, e3 = t and p = 4. Otherwise a = t and p = 3.
  - e[p] = a+e[p], a takes it, p++.
  - t = a+e[p]; a takes the old e[p], e[p] = t, p++.
  - t = (a mod 16)+8, plus e[p] if t<16; a takes the old e[p], e[p] = t, p++.
  - For each p left up to 15, e[p] = a+e[p]+1 and a takes it.
  - Finally a = x+15.
- R6: The first response index is the low nibble of entry 7 after the rounds, or 1 if that nibble is 0.
- R7: During a response, each `rx_valid` makes `tx_ready` high for the next cycle. `tx_bit` then holds bit 0 of the entry at the current index.
- R8: With region 0 the index steps up, and with region 1 it steps down, both modulo 16. The response ends when the index reaches 0, so it has 16−s bits for region 0 and s bits for region 1, where s is the first index.
- R9: `done` is high only in the cycle of the last `tx_ready`. The state then remains for the next command, which mixes the already mixed state.
- R10: `rx_valid` has no effect after the initial bits unless a response is in progress. Such pulses raise no `tx_ready` and do not change the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also loads the state |
| region | input | 1 | Table and step-direction select, sampled during reset |
| rx_valid | input | 1 | Host bit strobe |
| rx_bit | input | 1 | Host bit value |
| start | input | 1 | Command request pulse |
| tx_ready | output | 1 | Response bit valid, one cycle per host strobe |
| tx_bit | output | 1 | Response bit value |
| done | output | 1 | Marks the final response bit |

## Verification
The assertions assume that `region` is stable through reset and that `rx_valid` is only a single-cycle strobe. They also assume that `start` comes only in the idle phase once the initial nibbles are in. The stimulus follows these rules by spacing every host strobe with an idle cycle and waiting a fixed margin longer than the worst-case mixing time before the response. It also pulses `start` only outside a command, except for one deliberate early pulse during the initial nibble intake. The stray strobes sent while mixing and after `done` fall in phases where the design is required to ignore them.

// File: rtl/cmp_mix_pkg.sv
// Shared constants and state encodings for the challenge-response nibble mixer.
// Assumes a 16-entry working half of a 32-nibble table and 8-bit words.
package cmp_mix_pkg;
    localparam int unsigned NIB_W   = 4;
    localparam int unsigned WORD_W  = 8;
    localparam int unsigned FULL_N  = 32;
    localparam int unsigned HALF_N  = 16;
    localparam int unsigned IDX_W   = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // Top-level phase of the handshake
    typedef enum logic [1:0] {
        PH_INIT = 2'd0,
        PH_IDLE = 2'd1,
        PH_MIX  = 2'd2,
        PH_RESP = 2'd3
    } phase_t;

    // Micro-step of the mixing round engine
    typedef enum logic [3:0] {
        MX_IDLE = 4'd0,
        MX_LOAD = 4'd1,
        MX_S1   = 4'd2,
        MX_S2   = 4'd3,
        MX_S3   = 4'd4,
        MX_S4   = 4'd5,
        MX_S5   = 4'd6,
        MX_S6   = 4'd7,
        MX_TAIL = 4'd8,
        MX_NEXT = 4'd9
    } mix_step_t;
endpackage

// File: rtl/cmp_state_file.sv
// Working state of 16 words with one write port and full parallel read.
// On reset each word is loaded with the upper-half nibble of the table that
// region selects. Assumes at most one writer per cycle (arbitrated by the top).
module cmp_state_file
    import cmp_mix_pkg::*;
#(
    parameter int unsigned           ENTRIES = HALF_N,
    parameter int unsigned           W       = WORD_W,
    parameter logic [FULL_N*NIB_W-1:0] TABLE_A = '0,
    parameter logic [FULL_N*NIB_W-1:0] TABLE_B = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      region,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [W-1:0]              wr_data,
    output logic [ENTRIES-1:0][W-1:0] mem_q
);
    localparam int unsigned BASE = FULL_N - ENTRIES;

    for (genvar k = 0; k < ENTRIES; k++) begin : g_word
        localparam logic [NIB_W-1:0] INIT_A = TABLE_A[NIB_W*(BASE+k) +: NIB_W];
        localparam logic [NIB_W-1:0] INIT_B = TABLE_B[NIB_W*(BASE+k) +: NIB_W];

        // Reset-time table load, then single-port writes
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[k] <= {{(W-NIB_W){1'b0}}, (region ? INIT_B : INIT_A)};
            end else if (wr_en && (wr_idx == IDX_W'(k))) begin
                mem_q[k] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/cmp_nibble_rx.sv
// Takes in the eight initial host bits MSB-first. The first nibble is dropped
// (its table slot lies outside the working half); the second nibble is issued
// as a write request and the block then reports completion.
// Assumes rx_valid is a one-cycle strobe per bit.
module cmp_nibble_rx
    import cmp_mix_pkg::*;
#(
    parameter int unsigned BITS = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              bit_valid,
    input  logic              bit_in,
    output logic              nib_wr,
    output logic [WORD_W-1:0] nib_data,
    output logic              complete
);
    localparam int unsigned CNT_W = $clog2(BITS);

    logic [CNT_W-1:0] cnt_q;
    logic [NIB_W-2:0] sh_q;
    logic             take;

    assign take     = en && bit_valid && !complete;
    assign nib_wr   = take && (cnt_q == CNT_W'(BITS-1));
    assign nib_data = {{(WORD_W-NIB_W){1'b0}}, sh_q, bit_in};

    // Bit counter, shift register and completion flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            sh_q     <= '0;
            complete <= 1'b0;
        end else if (take) begin
            cnt_q <= cnt_q + 1'b1;
            sh_q  <= {sh_q[NIB_W-3:0], bit_in};
            if (cnt_q == CNT_W'(BITS-1)) complete <= 1'b1;
        end
    end

    // R2: the nibble write happens exactly once, on the eighth bit
    p_single_nibble_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        nib_wr |=> (complete && !nib_wr));
endmodule

// File: rtl/cmp_mix_round.sv
// Sequential engine for ROUNDS mixing rounds over a 16-word state, one pass
// step per cycle and one state write per cycle at most. Reads the state
// through the parallel read port; a write lands before the next step reads.
// Assumes go is only pulsed while the engine is idle.
module cmp_mix_round
    import cmp_mix_pkg::*;
#(
    parameter int unsigned ROUNDS = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           go,
    input  logic [HALF_N-1:0][WORD_W-1:0]  m_i,
    output logic                           wr_en,
    output logic [IDX_W-1:0]               wr_idx,
    output logic [WORD_W-1:0]              wr_data,
    output logic                           busy,
    output logic                           fin
);
    localparam int unsigned RND_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HALF_N - 1);

    mix_step_t         step_q, step_d;
    logic [WORD_W-1:0] a_q, a_d, x_q, x_d, t;
    logic [IDX_W-1:0]  b_q, b_d;
    logic [RND_W-1:0]  rnd_q, rnd_d;
    logic [WORD_W-1:0] mb;

    assign mb   = m_i[b_q];
    assign busy = (step_q != MX_IDLE);

    // Next-state and write-port logic for one micro-step
    always_comb begin
        step_d  = step_q;
        a_d     = a_q;
        x_d     = x_q;
        b_d     = b_q;
        rnd_d   = rnd_q;
        wr_en   = 1'b0;
        wr_idx  = b_q;
        wr_data = '0;
        fin     = 1'b0;
        t       = '0;
        unique case (step_q)
            MX_IDLE: begin
                if (go) begin
                    rnd_d  = '0;
                    step_d = MX_LOAD;
                end
            end
            MX_LOAD: begin
                x_d    = m_i[HALF_N-1];
                a_d    = m_i[HALF_N-1];
                step_d = MX_S1;
            end
            MX_S1: begin
                t       = a_q + m_i[1] + 8'd1;
                wr_en   = 1'b1;
                wr_idx  = 4'd1;
                wr_data = t;
                a_d     = t;
                step_d  = MX_S2;
            end
            MX_S2: begin
                t       = a_q + m_i[2] + 8'd1;
                wr_en   = 1'b1;
                wr_idx  = 4'd2;
                wr_data = ~t;
                a_d     = m_i[2];
                step_d  = MX_S3;
            end
            MX_S3: begin
                t = {4'h0, a_q[3:0]} + {4'h0, m_i[3][3:0]} + 8'd1;
                if (t < 8'd16) begin
                    wr_en   = 1'b1;
                    wr_idx  = 4'd3;
                    wr_data = t;
                    a_d     = m_i[3];
                    b_d     = 4'd4;
                end else begin
                    a_d = t;
                    b_d = 4'd3;
                end
                step_d = MX_S4;
            end
            MX_S4: begin
                t       = a_q + mb;
                wr_en   = 1'b1;
                wr_data = t;
                a_d     = t;
                b_d     = b_q + 4'd1;
                step_d  = MX_S5;
            end
            MX_S5: begin
                t       = a_q + mb;
                wr_en   = 1'b1;
                wr_data = t;
                a_d     = mb;
                b_d     = b_q + 4'd1;
                step_d  = MX_S6;
            end
            MX_S6: begin
                t = {4'h0, a_q[3:0]} + 8'd8;
                if (t < 8'd16) t = t + mb;
                wr_en   = 1'b1;
                wr_data = t;
                a_d     = mb;
                b_d     = b_q + 4'd1;
                step_d  = MX_TAIL;
            end
            MX_TAIL: begin
                t       = a_q + mb + 8'd1;
                wr_en   = 1'b1;
                wr_data = t;
                a_d     = t;
                b_d     = b_q + 4'd1;
                if (b_q == LAST_IDX) step_d = MX_NEXT;
            end
            MX_NEXT: begin
                t   = x_q + 8'h0F;
                a_d = t;
                x_d = {4'h0, t[3:0]};
                if (t[3:0] == 4'hF) begin
                    if (rnd_q == RND_W'(ROUNDS-1)) begin
                        fin    = 1'b1;
                        step_d = MX_IDLE;
                    end else begin
                        rnd_d  = rnd_q + 1'b1;
                        step_d = MX_LOAD;
                    end
                end else begin
                    step_d = MX_S1;
                end
            end
            default: step_d = MX_IDLE;
        endcase
    end

    // Micro-step registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= MX_IDLE;
            a_q    <= '0;
            x_q    <= '0;
            b_q    <= '0;
            rnd_q  <= '0;
        end else begin
            step_q <= step_d;
            a_q    <= a_d;
            x_q    <= x_d;
            b_q    <= b_d;
            rnd_q  <= rnd_d;
        end
    end

    // R5: the closing loop has walked the pointer around to 0 before the x update
    p_tail_wraps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == MX_NEXT) |-> (b_q == 4'd0));
    // R5: after the conditional step the pointer sits at 3 or 4
    p_cond_pointer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == MX_S4) |-> (b_q == 4'd3 || b_q == 4'd4));
    // R4: the pass counter x stays a 4-bit value between passes
    p_x_nibble_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == MX_S1 && $past(step_q) == MX_NEXT) |-> (x_q[7:4] == 4'h0));
endmodule

// File: rtl/cmp_resp_seq.sv
// Response walker: latches the start index when armed, then for each host
// strobe presents bit 0 of the current entry and steps the index up or down.
// Assumes arm is pulsed only while inactive and the state is frozen meanwhile.
module cmp_resp_seq
    import cmp_mix_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              step_down,
    input  logic [IDX_W-1:0]  first_nib,
    input  logic [HALF_N-1:0] lsb_v,
    input  logic              rx_valid,
    output logic              tx_bit,
    output logic              tx_ready,
    output logic              done,
    output logic              active
);
    logic [IDX_W-1:0] idx_q, idx_nx;

    assign idx_nx = step_down ? (idx_q - 4'd1) : (idx_q + 4'd1);

    // Index walk, response bit and completion strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            active   <= 1'b0;
            tx_bit   <= 1'b0;
            tx_ready <= 1'b0;
            done     <= 1'b0;
        end else begin
            tx_ready <= 1'b0;
            done     <= 1'b0;
            if (arm) begin
                idx_q  <= (first_nib == '0) ? 4'd1 : first_nib;
                active <= 1'b1;
            end else if (active && rx_valid) begin
                tx_bit   <= lsb_v[idx_q];
                tx_ready <= 1'b1;
                idx_q    <= idx_nx;
                if (idx_nx == '0) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    // R6: a live response never points at entry 0
    p_index_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (idx_q != '0));
    // R9: completion only comes with a response bit
    p_done_with_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> tx_ready);
endmodule

// File: rtl/cmp_mix_engine.sv
// Top of the challenge-response nibble mixer: sequences initial nibble intake,
// command start, mixing rounds and the response walk; arbitrates the state
// write port. Assumes region is held stable while rst_n is low.
module cmp_mix_engine
    import cmp_mix_pkg::*;
#(
    parameter int unsigned             ROUNDS  = 3,
    parameter logic [FULL_N*NIB_W-1:0] TABLE_A = 128'h3C9E_07B1_5A2F_D864_1E7C_93B0_6F25_A4D8,
    parameter logic [FULL_N*NIB_W-1:0] TABLE_B = 128'h8D13_F6A0_2C59_E74B_0B3E_5D81_C7A2_946F
) (
    input  logic clk,
    input  logic rst_n,
    input  logic region,
    input  logic rx_valid,
    input  logic rx_bit,
    input  logic start,
    output logic tx_ready,
    output logic tx_bit,
    output logic done
);
    localparam logic [IDX_W-1:0] HOST_IDX  = 4'd1;
    localparam int unsigned      FIRST_SEL = 7;

    phase_t                        phase_q;
    logic                          region_q;
    logic [HALF_N-1:0][WORD_W-1:0] mem_q;
    logic [HALF_N-1:0]             lsb_v;
    logic                          nib_wr, nib_complete;
    logic [WORD_W-1:0]             nib_data;
    logic                          mix_go, mix_wr, mix_busy, mix_fin;
    logic [IDX_W-1:0]              mix_idx;
    logic [WORD_W-1:0]             mix_data;
    logic                          wr_en;
    logic [IDX_W-1:0]              wr_idx;
    logic [WORD_W-1:0]             wr_data;
    logic                          resp_active, resp_done;

    assign mix_go = (phase_q == PH_IDLE) && start;

    // Write-port arbitration: intake and mixing never overlap in phase
    assign wr_en   = nib_wr || mix_wr;
    assign wr_idx  = nib_wr ? HOST_IDX : mix_idx;
    assign wr_data = nib_wr ? nib_data : mix_data;

    // Bit 0 of every entry for the response walker
    always_comb begin
        for (int k = 0; k < HALF_N; k++) lsb_v[k] = mem_q[k][0];
    end

    // Handshake phase sequencing and region capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_INIT;
            region_q <= region;
        end else begin
            unique case (phase_q)
                PH_INIT: if (nib_complete) phase_q <= PH_IDLE;
                PH_IDLE: if (start)        phase_q <= PH_MIX;
                PH_MIX:  if (mix_fin)      phase_q <= PH_RESP;
                PH_RESP: if (resp_done)    phase_q <= PH_IDLE;
                default:                   phase_q <= PH_IDLE;
            endcase
        end
    end

    cmp_state_file #(
        .ENTRIES (HALF_N),
        .W       (WORD_W),
        .TABLE_A (TABLE_A),
        .TABLE_B (TABLE_B)
    ) i_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .region  (region),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .mem_q   (mem_q)
    );

    cmp_nibble_rx #(
        .BITS (2 * NIB_W)
    ) i_intake (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (phase_q == PH_INIT),
        .bit_valid (rx_valid),
        .bit_in    (rx_bit),
        .nib_wr    (nib_wr),
        .nib_data  (nib_data),
        .complete  (nib_complete)
    );

    cmp_mix_round #(
        .ROUNDS (ROUNDS)
    ) i_mix (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (mix_go),
        .m_i     (mem_q),
        .wr_en   (mix_wr),
        .wr_idx  (mix_idx),
        .wr_data (mix_data),
        .busy    (mix_busy),
        .fin     (mix_fin)
    );

    cmp_resp_seq i_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       ((phase_q == PH_MIX) && mix_fin),
        .step_down (region_q),
        .first_nib (mem_q[FIRST_SEL][IDX_W-1:0]),
        .lsb_v     (lsb_v),
        .rx_valid  (rx_valid),
        .tx_bit    (tx_bit),
        .tx_ready  (tx_ready),
        .done      (resp_done),
        .active    (resp_active)
    );

    assign done = resp_done;

    // R3: mixing never runs during nibble intake
    p_no_mix_in_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_INIT) |-> !mix_busy);
    // R4: the two state writers are never active together
    p_one_writer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(nib_wr && mix_wr));
    // R10: a response bit only follows a strobe taken during the response phase
    p_ready_needs_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> ($past(rx_valid) && $past(phase_q == PH_RESP)));
    // R7: the response walker is live exactly in the response phase
    p_resp_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_active |-> (phase_q == PH_RESP));
endmodule

// File: tb/test_cmp_mix_engine.sv
`timescale 1ns/1ps
module test_cmp_mix_engine;
    localparam logic [127:0] TBL_A = 128'h3C9E_07B1_5A2F_D864_1E7C_93B0_6F25_A4D8;
    localparam logic [127:0] TBL_B = 128'h8D13_F6A0_2C59_E74B_0B3E_5D81_C7A2_946F;
    localparam int MIX_WAIT = 900;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic region = 1'b0;
    logic rx_valid = 1'b0;
    logic rx_bit = 1'b0;
    logic start = 1'b0;
    logic tx_ready, tx_bit, done;

    int n_checks = 0;
    int n_fail   = 0;
    int mm[16];

    always #2.5 clk = ~clk;

    cmp_mix_engine #(.ROUNDS(3), .TABLE_A(TBL_A), .TABLE_B(TBL_B)) i_cmp_mix_engine (
        .clk(clk), .rst_n(rst_n), .region(region), .rx_valid(rx_valid),
        .rx_bit(rx_bit), .start(start), .tx_ready(tx_ready), .tx_bit(tx_bit), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One host strobe; outputs are sampled at the falling edge after capture
    task automatic send_bit(input bit v, output bit rdy, output bit b, output bit d);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_bit   = v;
        @(negedge clk);
        rx_valid = 1'b0;
        rdy = tx_ready;
        b   = tx_bit;
        d   = done;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Reference round on the 16-word model, 8-bit wraparound
    task automatic model_round();
        int a, x, t, b;
        x = mm[15];
        a = x;
        do begin
            a = (a + mm[1] + 1) & 255; mm[1] = a;
            a = (a + mm[2] + 1) & 255; t = mm[2]; mm[2] = (~a) & 255; a = t;
            b = 3;
            a = (a & 15) + (mm[3] & 15) + 1;
            if (a < 16) begin t = mm[3]; mm[3] = a; a = t; b = 4; end
            a = (a + mm[b]) & 255; mm[b] = a; b++;
            a = (a + mm[b]) & 255; t = mm[b]; mm[b] = a; a = t; b++;
            a = (a & 15) + 8;
            if (a < 16) a = (a + mm[b]) & 255;
            t = mm[b]; mm[b] = a; a = t; b++;
            do begin
                a = (a + mm[b] + 1) & 255; mm[b] = a; b = (b + 1) & 15;
            end while (b != 0);
            a = (x + 15) & 255;
            x = a & 15;
        end while (x != 15);
    endtask

    task automatic run_case(input bit reg_sel, input int nib_a, input int nib_b, input bit early_start);
        bit rdy, b, d;
        int idx, n_bits, k;
        logic [127:0] tbl;
        region = reg_sel;
        rst_n  = 1'b0;
        idle(2);
        // R1: outputs quiet in reset
        check(tx_ready == 1'b0 && done == 1'b0, "R1 reset outputs", {tx_ready, done}, 0);
        rst_n = 1'b1;
        tbl = reg_sel ? TBL_B : TBL_A;
        for (int i = 0; i < 16; i++) mm[i] = int'(tbl[4*(16+i) +: 4]);
        // R2: intake of the two nibbles, MSB first
        for (int i = 3; i >= 0; i--) begin
            send_bit(nib_a[i], rdy, b, d);
            check(rdy == 1'b0, "R2 no response during intake", rdy, 0);
        end
        if (early_start) begin
            // R3: start before intake completes is ignored
            @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
            idle(20);
            check(tx_ready == 1'b0 && done == 1'b0, "R3 early start ignored", done, 0);
        end
        for (int i = 3; i >= 0; i--) send_bit(nib_b[i], rdy, b, d);
        mm[1] = nib_b;
        idle(3);
        for (int cmd = 0; cmd < 2; cmd++) begin
            @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
            // R10: stray strobes while mixing
            send_bit(1'b1, rdy, b, d);
            check(rdy == 1'b0 && d == 1'b0, "R10 strobe while mixing ignored", rdy, 0);
            idle(MIX_WAIT);
            for (int r = 0; r < 3; r++) model_round();
            idx = mm[7] & 15;
            if (idx == 0) idx = 1;
            n_bits = reg_sel ? idx : 16 - idx;
            for (k = 0; k < n_bits; k++) begin
                send_bit(1'b0, rdy, b, d);
                // R4 R5 R6 R7 R8: each bit comes from the mixed entry at the walked index
                check(rdy == 1'b1, "R7 tx_ready per strobe", rdy, 1);
                check(b == mm[idx][0], "R4 R5 R6 R8 response bit", b, mm[idx] & 1);
                // R9: done only with the last bit
                check(d == (k == n_bits - 1), "R9 done timing", d, k == n_bits - 1);
                idx = reg_sel ? ((idx + 15) & 15) : ((idx + 1) & 15);
            end
            idle(2);
            // R10: strobe after done, in idle
            send_bit(1'b1, rdy, b, d);
            check(rdy == 1'b0 && d == 1'b0, "R10 strobe in idle ignored", rdy, 0);
            idle(2);
        end
    endtask

    initial begin
        for (int rs = 0; rs < 2; rs++) begin
            for (int c = 0; c < 20; c++) begin
                run_case(rs[0], (c * 7 + rs * 3) & 15, (c * 11 + 5 + rs) & 15, c == 3);
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 190000; i++) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule